// File: doc/BRIEF.md
# Glitch-free coefficient staging buffer

This block sits between a host control port and the coefficient memory of an audio signal processor. The host can rewrite a small group of coefficients, such as the five taps of one second-order filter section, while the program keeps running. Each update goes first into a bank of shadow slots. Each slot holds a target address and a data word, and a mask selects which slots take part. A write to an arm register requests a commit. The copy waits for the next audio frame-start pulse, then moves every selected slot into coefficient memory in one short burst. While the burst runs, processor reads are stalled, so no frame ever computes with a mix of old and new values.

A run bit in the control register lets the host stop processing for bulk downloads. While processing is halted, processor reads are refused and host writes into the coefficient memory region go straight into the memory. While it runs, such direct writes are dropped, and the staging path is the only way to change coefficients. Write access to the memory has a single owner at any time. During a burst, the copy engine owns the port and all host writes are held off with a busy signal.

Top module: `coef_safeload`

## Requirements
- R1: After reset, `core_run`, `hw_busy`, `core_stall`, `commit_done` and `cr_valid` are all 0.
- R2: While `core_run` is 0, a host write to an address below the memory depth (0x000 to 0x0FF by default) stores `hw_data` at that address, and a processor read request produces no `cr_valid`.
- R3: A host write to the control register at 0x81C loads `core_run` from data bit 0. A read request made while `core_run` is 1 and `core_stall` is 0 returns `cr_valid` = 1 in the next cycle, with the stored word on `cr_data`.
- R4: While `core_run` is 1, a host write to the memory region is dropped. The stored word is unchanged.
- R5: Shadow slot i takes its target address from data bits [7:0] at 0x800+2i and its data word at 0x801+2i. The slot mask is taken from data bits [4:0] at 0x80A, with bit i selecting slot i. Writing 0x80B with data bit 0 = 1 arms a commit and clears `commit_done`.
- R6: An armed commit starts only on a `frame_start` pulse that arrives in a later cycle than the arming write. A `frame_start` pulse with nothing armed has no effect.
- R7: A commit lasts exactly SLOTS cycles, and `core_stall` and `hw_busy` are high throughout. Slots are visited in ascending order, and only masked slots are written. When two slots name the same address, the higher slot's word remains.
- R8: A read request made while `core_stall` is high gets no `cr_valid`. Reads before the burst return the complete old set, and reads after it return the complete new set.
- R9: `commit_done` rises in the cycle the burst ends and stays high until the next arming write.
- R10: A host write that is presented while `hw_busy` is high is not lost. It takes effect in the first cycle after `hw_busy` falls, provided the host keeps `hw_valid` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_valid | input | 1 | Host write request, held until accepted |
| hw_addr | input | 12 | Host write address |
| hw_data | input | DATA_W | Host write data |
| hw_busy | output | 1 | Host write held off this cycle |
| frame_start | input | 1 | One-cycle audio frame boundary pulse |
| cr_en | input | 1 | Processor coefficient read request |
| cr_addr | input | RA_W | Processor read address |
| cr_valid | output | 1 | Read data valid, one cycle after the request |
| cr_data | output | DATA_W | Read data |
| core_stall | output | 1 | Commit burst in progress, reads refused |
| core_run | output | 1 | Processing enabled |
| commit_done | output | 1 | Last armed commit has finished |

## Verification
The commit path is exercised with several slot patterns. A mask with one slot cleared shows that unselected slots are skipped. Two slots aimed at one address show that the visit order is ascending. A single-slot commit that overlaps a held host write shows that the held write is applied later and not lost. Reads are issued before the frame pulse, during the stall and after it, which separates the old set, refusal and the new set. Direct memory writes are issued both halted and running, which shows how the run bit gates them. Frame pulses are also sent with nothing armed, to show they have no effect.

// File: rtl/sl_pkg.sv
// Shared constants and types for the coefficient staging buffer.
// Assumes a 12-bit host address space and at most five shadow slots,
// so the slot window 0x800..0x809 never reaches the mask register.
package sl_pkg;
    localparam int          HOST_AW   = 12;
    localparam logic [11:0] SLOT_BASE = 12'h800;
    localparam logic [11:0] MASK_REG  = 12'h80A;
    localparam logic [11:0] ARM_REG   = 12'h80B;
    localparam logic [11:0] CTRL_REG  = 12'h81C;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_COPY
    } seq_state_e;

    typedef enum logic [2:0] {
        HW_NONE,
        HW_RAM,
        HW_SLOT_ADDR,
        HW_SLOT_DATA,
        HW_MASK,
        HW_ARM,
        HW_CTRL
    } hw_kind_e;
endpackage

// File: rtl/sl_host_decode.sv
// Host write decoder: classifies an accepted host write by target.
// Assumes the memory region (below 2**RA_W) lies below SLOT_BASE.
// Memory-region writes are classified only while processing is halted.
module sl_host_decode #(
    parameter int RA_W   = 8,
    parameter int SLOTS  = 5,
    parameter int SIDX_W = 3
) (
    input  logic                       hw_valid,
    input  logic [sl_pkg::HOST_AW-1:0] hw_addr,
    input  logic                       hw_busy,
    input  logic                       core_run,
    output sl_pkg::hw_kind_e           kind,
    output logic [SIDX_W-1:0]          slot_idx
);
    import sl_pkg::*;

    localparam int DEPTH = 1 << RA_W;

    logic [HOST_AW-1:0] slot_off;

    assign slot_off = hw_addr - SLOT_BASE;

    // Decode one accepted host write into a write kind and a slot index.
    always_comb begin
        kind     = HW_NONE;
        slot_idx = '0;
        if (hw_valid && !hw_busy) begin
            if (hw_addr < HOST_AW'(DEPTH)) begin
                if (!core_run) begin
                    kind = HW_RAM;
                end
            end else if (hw_addr >= SLOT_BASE && slot_off < HOST_AW'(2 * SLOTS)) begin
                kind     = slot_off[0] ? HW_SLOT_DATA : HW_SLOT_ADDR;
                slot_idx = SIDX_W'(slot_off[HOST_AW-1:1]);
            end else if (hw_addr == MASK_REG) begin
                kind = HW_MASK;
            end else if (hw_addr == ARM_REG) begin
                kind = HW_ARM;
            end else if (hw_addr == CTRL_REG) begin
                kind = HW_CTRL;
            end
        end
    end
endmodule

// File: rtl/sl_shadow_bank.sv
// Shadow slot bank: SLOTS address/data pairs plus a slot mask.
// Host writes load it. The copy engine reads one slot at a time by index.
// Assumes rd_idx stays below SLOTS whenever the result is used.
module sl_shadow_bank #(
    parameter int RA_W   = 8,
    parameter int DATA_W = 24,
    parameter int SLOTS  = 5,
    parameter int SIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sl_pkg::hw_kind_e  kind,
    input  logic [SIDX_W-1:0] slot_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SIDX_W-1:0] rd_idx,
    output logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SLOTS-1:0]  mask
);
    import sl_pkg::*;

    logic [RA_W-1:0]   addr_arr [SLOTS];
    logic [DATA_W-1:0] data_arr [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [RA_W-1:0]   addr_q;
        logic [DATA_W-1:0] data_q;

        // Capture this slot's target address or data word from the host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                data_q <= '0;
            end else if (slot_idx == SIDX_W'(i)) begin
                if (kind == HW_SLOT_ADDR) begin
                    addr_q <= wdata[RA_W-1:0];
                end
                if (kind == HW_SLOT_DATA) begin
                    data_q <= wdata;
                end
            end
        end

        assign addr_arr[i] = addr_q;
        assign data_arr[i] = data_q;
    end

    // Hold the slot-select mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (kind == HW_MASK) begin
            mask <= wdata[SLOTS-1:0];
        end
    end

    // Present the slot chosen by the copy engine.
    always_comb begin
        rd_addr = addr_arr[rd_idx];
        rd_data = data_arr[rd_idx];
    end
endmodule

// File: rtl/sl_commit_seq.sv
// Commit sequencer: latches an arm request, waits for a frame boundary,
// then walks all slots in ascending order, one per cycle.
// Assumes that no arm request arrives while copying (the host is held busy).
module sl_commit_seq #(
    parameter int SLOTS  = 5,
    parameter int SIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              frame_start,
    input  logic [SLOTS-1:0]  mask,
    output logic              copying,
    output logic [SIDX_W-1:0] idx,
    output logic              slot_we,
    output logic              done
);
    import sl_pkg::*;

    localparam logic [SIDX_W-1:0] LAST_IDX = SIDX_W'(SLOTS - 1);

    seq_state_e state;

    // Advance the arm / wait / copy state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (arm) begin
                        state <= SEQ_ARMED;
                        done  <= 1'b0;
                    end
                end
                SEQ_ARMED: begin
                    if (frame_start) begin
                        state <= SEQ_COPY;
                        idx   <= '0;
                    end
                end
                SEQ_COPY: begin
                    if (idx == LAST_IDX) begin
                        state <= SEQ_IDLE;
                        idx   <= '0;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Mark the copy phase and request a memory write for masked slots.
    always_comb begin
        copying = (state == SEQ_COPY);
        slot_we = copying && mask[idx];
    end
endmodule

// File: rtl/sl_param_ram.sv
// Coefficient memory model: one write port and one registered read port.
// A read and a write to the same address in one cycle return the old word.
module sl_param_ram #(
    parameter int RA_W   = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [RA_W-1:0]   raddr,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << RA_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word on the single write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Serve a read one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            if (re) begin
                rdata <= mem[raddr];
            end
        end
    end
endmodule

// File: rtl/coef_safeload.sv
// Top of the coefficient staging buffer. It ties together the host decoder,
// the shadow bank, the commit sequencer and the coefficient memory, and owns
// the run bit. The memory write port is owned by the copy engine during a
// burst and by the host otherwise. hw_busy holds the host off during a burst.
module coef_safeload #(
    parameter int RA_W   = 8,
    parameter int DATA_W = 24,
    parameter int SLOTS  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hw_valid,
    input  logic [sl_pkg::HOST_AW-1:0] hw_addr,
    input  logic [DATA_W-1:0]          hw_data,
    output logic                       hw_busy,
    input  logic                       frame_start,
    input  logic                       cr_en,
    input  logic [RA_W-1:0]            cr_addr,
    output logic                       cr_valid,
    output logic [DATA_W-1:0]          cr_data,
    output logic                       core_stall,
    output logic                       core_run,
    output logic                       commit_done
);
    import sl_pkg::*;

    localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    hw_kind_e          kind;
    logic [SIDX_W-1:0] slot_idx;
    logic [SIDX_W-1:0] copy_idx;
    logic [RA_W-1:0]   slot_addr;
    logic [DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]  slot_mask;
    logic              copying;
    logic              slot_we;
    logic              ram_we;
    logic [RA_W-1:0]   ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic              ram_re;
    logic              run_q;

    sl_host_decode #(
        .RA_W   (RA_W),
        .SLOTS  (SLOTS),
        .SIDX_W (SIDX_W)
    ) decode_i (
        .hw_valid (hw_valid),
        .hw_addr  (hw_addr),
        .hw_busy  (hw_busy),
        .core_run (run_q),
        .kind     (kind),
        .slot_idx (slot_idx)
    );

    sl_shadow_bank #(
        .RA_W   (RA_W),
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .SIDX_W (SIDX_W)
    ) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .slot_idx (slot_idx),
        .wdata    (hw_data),
        .rd_idx   (copy_idx),
        .rd_addr  (slot_addr),
        .rd_data  (slot_data),
        .mask     (slot_mask)
    );

    sl_commit_seq #(
        .SLOTS  (SLOTS),
        .SIDX_W (SIDX_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         ((kind == HW_ARM) && hw_data[0]),
        .frame_start (frame_start),
        .mask        (slot_mask),
        .copying     (copying),
        .idx         (copy_idx),
        .slot_we     (slot_we),
        .done        (commit_done)
    );

    sl_param_ram #(
        .RA_W   (RA_W),
        .DATA_W (DATA_W)
    ) ram_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ram_we),
        .waddr  (ram_waddr),
        .wdata  (ram_wdata),
        .re     (ram_re),
        .raddr  (cr_addr),
        .rvalid (cr_valid),
        .rdata  (cr_data)
    );

    // Hold the processing run bit from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (kind == HW_CTRL) begin
            run_q <= hw_data[0];
        end
    end

    // Give the memory write port to the copy engine or to the host.
    always_comb begin
        ram_we    = slot_we || (kind == HW_RAM);
        ram_waddr = copying ? slot_addr : hw_addr[RA_W-1:0];
        ram_wdata = copying ? slot_data : hw_data;
    end

    // Gate processor reads and expose the busy and stall status.
    always_comb begin
        ram_re     = cr_en && run_q && !copying;
        hw_busy    = copying;
        core_stall = copying;
        core_run   = run_q;
    end
endmodule

// File: rtl/coef_safeload_chk.sv
// Property checker for coef_safeload, bound to every instance of it.
// Stall lengths are counted here, so no property needs a long delay.
module coef_safeload_chk #(
    parameter int SLOTS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic cr_valid,
    input logic core_run,
    input logic core_stall,
    input logic commit_done
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] stall_cnt;

    // Count consecutive stall cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= '0;
        end else if (core_stall) begin
            stall_cnt <= stall_cnt + 1'b1;
        end else begin
            stall_cnt <= '0;
        end
    end

    assert_halt_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |=> !cr_valid);

    assert_start_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_stall) |-> $past(frame_start));

    assert_stall_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (stall_cnt < CNT_W'(SLOTS)));

    assert_stall_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |-> (stall_cnt == CNT_W'(SLOTS)));

    assert_no_read_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> !cr_valid);

    assert_done_after_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |-> commit_done);
endmodule

bind coef_safeload coef_safeload_chk #(
    .SLOTS (SLOTS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cr_valid    (cr_valid),
    .core_run    (core_run),
    .core_stall  (core_stall),
    .commit_done (commit_done)
);

// File: tb/coef_safeload_tb_top.sv
// Scoreboard bench for coef_safeload. The read task pushes the expected
// words into a queue, and a monitor pops and compares them when cr_valid is seen.
module coef_safeload_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RA_W   = 8;
    localparam int DATA_W = 24;
    localparam int SLOTS  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hw_valid = 1'b0;
    logic [11:0]       hw_addr = '0;
    logic [DATA_W-1:0] hw_data = '0;
    logic              hw_busy;
    logic              frame_start = 1'b0;
    logic              cr_en = 1'b0;
    logic [RA_W-1:0]   cr_addr = '0;
    logic              cr_valid;
    logic [DATA_W-1:0] cr_data;
    logic              core_stall;
    logic              core_run;
    logic              commit_done;

    int total = 0;
    int bad   = 0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    coef_safeload #(
        .RA_W   (RA_W),
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_valid    (hw_valid),
        .hw_addr     (hw_addr),
        .hw_data     (hw_data),
        .hw_busy     (hw_busy),
        .frame_start (frame_start),
        .cr_en       (cr_en),
        .cr_addr     (cr_addr),
        .cr_valid    (cr_valid),
        .cr_data     (cr_data),
        .core_stall  (core_stall),
        .core_run    (core_run),
        .commit_done (commit_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Host write, held while busy. Returns the number of held cycles.
    task automatic host_wr(input logic [11:0] a, input logic [DATA_W-1:0] d, output int held);
        held     = 0;
        hw_valid = 1'b1;
        hw_addr  = a;
        hw_data  = d;
        while (hw_busy) begin
            held++;
            @(negedge clk);
        end
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [DATA_W-1:0] d);
        int h;
        host_wr(a, d, h);
    endtask

    // Processor read. A served read pushes its expected word to the scoreboard.
    task automatic core_read(input logic [RA_W-1:0] a, input bit served,
                             input logic [DATA_W-1:0] exp, input string req);
        cr_en   = 1'b1;
        cr_addr = a;
        if (served) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
        end
        @(negedge clk);
        cr_en = 1'b0;
        if (!served) begin
            chk({req, " refused read"}, 32'(cr_valid), 32'd0);
        end
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Monitor: compare every read result with the front of the queue.
    always @(negedge clk) begin
        if (rst_n && cr_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R8 unexpected cr_valid act=1 exp=0");
            end else begin
                chk(tag_q.pop_front(), 32'(cr_data), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int held;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 core_run", 32'(core_run), 0);
        chk("R1 hw_busy", 32'(hw_busy), 0);
        chk("R1 core_stall", 32'(core_stall), 0);
        chk("R1 commit_done", 32'(commit_done), 0);
        chk("R1 cr_valid", 32'(cr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: halted direct writes land, reads refused
        wr(12'h010, 24'h000111);
        wr(12'h011, 24'h000222);
        wr(12'h012, 24'h000333);
        wr(12'h013, 24'h000444);
        wr(12'h030, 24'h000555);
        core_read(8'h10, 1'b0, '0, "R2");

        // R3: run bit, reads served
        wr(12'h81C, 24'h1);
        chk("R3 core_run", 32'(core_run), 1);
        core_read(8'h10, 1'b1, 24'h000111, "R3");
        core_read(8'h12, 1'b1, 24'h000333, "R3");

        // R4: direct write dropped while running
        wr(12'h030, 24'h00DEAD);
        core_read(8'h30, 1'b1, 24'h000555, "R4");

        // R5/R7: masked slots, duplicate target 0x11 in slots 1 and 4
        wr(12'h800, 24'h10); wr(12'h801, 24'hA00000);
        wr(12'h802, 24'h11); wr(12'h803, 24'hA11111);
        wr(12'h804, 24'h12); wr(12'h805, 24'hA22222);
        wr(12'h806, 24'h13); wr(12'h807, 24'hA33333);
        wr(12'h808, 24'h11); wr(12'h809, 24'hA44444);
        wr(12'h80A, 24'h1B);
        wr(12'h80B, 24'h1);
        chk("R5 commit_done after arm", 32'(commit_done), 0);

        // R6/R8: armed but no frame yet, old set still visible
        core_read(8'h10, 1'b1, 24'h000111, "R8 old set");
        core_read(8'h11, 1'b1, 24'h000222, "R8 old set");
        chk("R6 no copy before frame", 32'(core_stall), 0);

        pulse_frame();
        n = 0;
        while (core_stall && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk("R7 stall length", 32'(n), 32'(SLOTS));
        chk("R9 commit_done", 32'(commit_done), 1);
        core_read(8'h10, 1'b1, 24'hA00000, "R7 slot0");
        core_read(8'h11, 1'b1, 24'hA44444, "R7 later slot wins");
        core_read(8'h12, 1'b1, 24'h000333, "R7 masked-off slot");
        core_read(8'h13, 1'b1, 24'hA33333, "R8 new set");

        // R6: frame pulse with nothing armed
        pulse_frame();
        chk("R6 idle frame", 32'(core_stall), 0);
        chk("R9 done holds", 32'(commit_done), 1);

        // R8/R10: single-slot commit overlapped by a held host write
        wr(12'h800, 24'h20); wr(12'h801, 24'hB00000);
        wr(12'h80A, 24'h01);
        wr(12'h80B, 24'h1);
        chk("R9 done cleared on arm", 32'(commit_done), 0);
        pulse_frame();
        core_read(8'h20, 1'b0, '0, "R8 during stall");
        host_wr(12'h801, 24'hB11111, held);
        chk("R10 held cycles", 32'(held), 32'(SLOTS - 1));
        core_read(8'h20, 1'b1, 24'hB00000, "R10 first commit");
        wr(12'h80B, 24'h1);
        pulse_frame();
        repeat (SLOTS) @(negedge clk);
        core_read(8'h20, 1'b1, 24'hB11111, "R10 held write kept");

        // R2: halt again, direct write lands
        wr(12'h81C, 24'h0);
        chk("R2 core_run off", 32'(core_run), 0);
        wr(12'h040, 24'h00C0DE);
        wr(12'h81C, 24'h1);
        core_read(8'h40, 1'b1, 24'h00C0DE, "R2 direct write");

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", 32'(exp_q.size()), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule